// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

One timer/counter channel built around a pair of byte registers. On each machine-cycle enable it advances, provided it is running. It counts either the enables themselves or falling edges seen on an external count pin. A four-bit control field chooses the counter geometry: a 13-bit counter with a 5-bit prescaler in the low byte, a full 16-bit counter, an 8-bit counter that reloads from the high byte, or a split mode that runs the two bytes as separate 8-bit counters. When the active width rolls over to zero, a sticky overflow flag is set. Software clears it with a strobe.

In split mode the high byte counts machine cycles under a run bit that belongs to a neighbouring channel. Its rollover leaves the block as a one-cycle pulse, which feeds the neighbour's flag. A parameter states whether this channel supports split mode. A channel built without it holds its count when mode 3 is selected. Counting can also be gated by an external level, so the counter measures how long a pin stays high.

Top module: `tmr_chan`

## Requirements
- R1: After asynchronous reset, `cnt_o` is 0x0000 and both `flag_o` and `hi_ovf_o` are 0.
- R2: `ctrl_i` is decoded as follows. Bit 3 is the gate enable. Bit 2 selects the count source (0 = machine-cycle enables, 1 = external falling edges). Bits 1:0 select the mode: 00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split.
- R3: The low-side counter advances only while `run_i` is 1 and either bit 3 of `ctrl_i` is 0 or `ext_gate_i` is 1. Otherwise the count does not change.
- R4: With count source 0, the counter advances by one on each clock edge where `mc_en_i` is 1. It never changes on an edge where `mc_en_i` is 0.
- R5: With count source 1, `ext_cnt_i` is sampled on each `mc_en_i`. A sample of 1 followed by a sample of 0 on the next enable marks a falling edge. The count goes up by one at the following enable, never at the enable that saw the low sample.
- R6: In mode 00, bits 4:0 of the low byte count. When they wrap, they carry into the high byte. Bits 7:5 of the low byte are never changed by counting. The flag is set when 0x1F/0xFF wraps to zero.
- R7: In mode 01, `cnt_o` counts as one 16-bit value. A step from 0xFFFF to 0x0000 sets the flag.
- R8: In mode 10, the low byte counts. On a step from 0xFF it loads the high byte and sets the flag. Counting never changes the high byte.
- R9: In mode 11 on a split-capable channel, the low byte is an 8-bit counter that sets the flag on wrap. The high byte counts each `mc_en_i` while `other_run_i` is 1. Its wrap from 0xFF produces a one-cycle `hi_ovf_o` pulse and leaves `flag_o` alone. On a channel built with `SPLIT_EN = 0`, mode 11 holds both bytes.
- R10: `flag_o` stays set until `flag_clr_i` is asserted. If a clear and an overflow fall in the same cycle, the flag stays set.
- R11: A write strobe to either byte takes that byte from `wr_data_i` on the next edge. While any write strobe is active, counting is suppressed for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | One-clock machine-cycle enable |
| ext_cnt_i | input | 1 | External count pin |
| ext_gate_i | input | 1 | External gate level |
| run_i | input | 1 | Run bit of this channel |
| ctrl_i | input | 4 | Gate, count source, mode[1:0] |
| other_run_i | input | 1 | Neighbour's run bit, used by the high byte in split mode |
| wr_lo_i | input | 1 | Low-byte write strobe |
| wr_hi_i | input | 1 | High-byte write strobe |
| wr_data_i | input | BYTE_W | Write data |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| cnt_o | output | 2*BYTE_W | {high byte, low byte} |
| flag_o | output | 1 | Sticky overflow flag |
| hi_ovf_o | output | 1 | Split-mode high-byte overflow pulse for the neighbour |

## Verification
The hold and stability properties assume several things about the inputs. `ctrl_i`, `run_i` and `ext_gate_i` are synchronous to the clock and change only between machine cycles. Write strobes, clear strobes and the enable all last one clock. The stimulus drives every input on the falling clock edge and never uses multi-cycle strobes. The pulse-width property on `hi_ovf_o` also needs at least two clocks between enables; the bench keeps every enable followed by an idle clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRE13   = 2'b00,
    MODE_FULL16  = 2'b01,
    MODE_RELOAD8 = 2'b10,
    MODE_SPLIT   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic pin_i,
  output logic fall_o
);
  logic samp_q, fall_q;

  // fall_q is held one machine cycle so the count moves on the following enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (smp_en_i) begin
      samp_q <= pin_i;
      fall_q <= samp_q & ~pin_i;
    end
  end

  assign fall_o = fall_q;
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic      mc_en_i,
  input  logic      fall_i,
  input  logic      run_i,
  input  logic      ext_gate_i,
  input  tmr_ctrl_t ctrl_i,
  output logic      tick_o
);
  logic enable;
  logic src_evt;

  assign enable  = run_i & (~ctrl_i.gate | ext_gate_i);
  assign src_evt = ctrl_i.ext_src ? fall_i : 1'b1;
  assign tick_o  = enable & mc_en_i & src_evt;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              lo_tick_i,
  input  logic              hi_tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [PRE_W-1:0]  PRE_ONE  = PRE_W'(1);
  localparam logic [BYTE_W-1:0] BYTE_ONE = BYTE_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [CNT_W-1:0]  full_nxt;
  logic              wr_any;

  assign wr_any   = wr_lo_i | wr_hi_i;
  assign full_nxt = {hi_q, lo_q} + CNT_ONE;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    if (wr_any) begin
      if (wr_lo_i) lo_d = wr_data_i;
      if (wr_hi_i) hi_d = wr_data_i;
    end else begin
      unique case (mode_i)
        MODE_PRE13: if (lo_tick_i) begin
          lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_ONE;
          if (&lo_q[PRE_W-1:0]) begin
            hi_d     = hi_q + BYTE_ONE;
            ovf_lo_o = &hi_q;
          end
        end
        MODE_FULL16: if (lo_tick_i) begin
          {hi_d, lo_d} = full_nxt;
          ovf_lo_o     = &{hi_q, lo_q};
        end
        MODE_RELOAD8: if (lo_tick_i) begin
          if (&lo_q) begin
            lo_d     = hi_q;
            ovf_lo_o = 1'b1;
          end else begin
            lo_d = lo_q + BYTE_ONE;
          end
        end
        MODE_SPLIT: begin
          if (lo_tick_i) begin
            lo_d     = lo_q + BYTE_ONE;
            ovf_lo_o = &lo_q;
          end
          if (hi_tick_i) begin
            hi_d     = hi_q + BYTE_ONE;
            ovf_hi_o = &hi_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mc_en_i,
  input  logic                ext_cnt_i,
  input  logic                ext_gate_i,
  input  logic                run_i,
  input  logic [3:0]          ctrl_i,
  input  logic                other_run_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic                flag_clr_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                flag_o,
  output logic                hi_ovf_o
);
  tmr_ctrl_t         ctrl;
  logic              fall;
  logic              tick;
  logic              lo_tick, hi_tick;
  logic              ovf_lo, ovf_hi;
  logic [BYTE_W-1:0] lo, hi;
  logic              hi_ovf_q;

  assign ctrl = tmr_ctrl_t'(ctrl_i);

  tmr_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_en_i (mc_en_i),
    .pin_i    (ext_cnt_i),
    .fall_o   (fall)
  );

  tmr_tick_gen u_tick (
    .mc_en_i    (mc_en_i),
    .fall_i     (fall),
    .run_i      (run_i),
    .ext_gate_i (ext_gate_i),
    .ctrl_i     (ctrl),
    .tick_o     (tick)
  );

  generate
    if (SPLIT_EN) begin : g_split
      assign lo_tick = tick;
      assign hi_tick = mc_en_i & other_run_i;
    end else begin : g_nosplit
      // mode 3 halts a channel that cannot split
      assign lo_tick = tick & (ctrl.mode != MODE_SPLIT);
      assign hi_tick = 1'b0;
    end
  endgenerate

  tmr_count #(
    .BYTE_W (BYTE_W),
    .PRE_W  (PRE_W)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (ctrl.mode),
    .lo_tick_i (lo_tick),
    .hi_tick_i (hi_tick),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .lo_o      (lo),
    .hi_o      (hi),
    .ovf_lo_o  (ovf_lo),
    .ovf_hi_o  (ovf_hi)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_lo),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_ovf_q <= 1'b0;
    else         hi_ovf_q <= ovf_hi;
  end

  assign hi_ovf_o = hi_ovf_q;
  assign cnt_o    = {hi, lo};
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mc_en_i,
  input logic                ext_gate_i,
  input logic                run_i,
  input logic [3:0]          ctrl_i,
  input logic                wr_lo_i,
  input logic                wr_hi_i,
  input logic [BYTE_W-1:0]   wr_data_i,
  input logic                flag_clr_i,
  input logic [2*BYTE_W-1:0] cnt_o,
  input logic                flag_o,
  input logic                hi_ovf_o
);
  logic no_wr;
  assign no_wr = !wr_lo_i && !wr_hi_i;

  assert_no_enable_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mc_en_i && no_wr) |=> $stable(cnt_o));

  assert_stopped_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && no_wr && ctrl_i[1:0] != 2'b11) |=> $stable(cnt_o));

  assert_gated_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[3] && !ext_gate_i && no_wr && ctrl_i[1:0] != 2'b11) |=> $stable(cnt_o));

  assert_wr_lo_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_o[BYTE_W-1:0] == $past(wr_data_i));

  assert_wr_hi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> cnt_o[2*BYTE_W-1:BYTE_W] == $past(wr_data_i));

  assert_reload_hi_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b10 && !wr_hi_i) |=> $stable(cnt_o[2*BYTE_W-1:BYTE_W]));

  assert_pre_upper_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b00 && !wr_lo_i) |=> $stable(cnt_o[BYTE_W-1:PRE_W]));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_hi_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_ovf_o |=> !hi_ovf_o);
endmodule

bind tmr_chan tmr_chan_chk #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) chk_i (.*);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mc_en_i = 1'b0;
  logic        ext_cnt_i = 1'b0;
  logic        ext_gate_i = 1'b0;
  logic        run_i = 1'b0;
  logic [3:0]  ctrl_i = 4'b0000;
  logic        other_run_i = 1'b0;
  logic        wr_lo_i = 1'b0;
  logic        wr_hi_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic        flag_clr_i = 1'b0;
  logic [15:0] cnt_o, cnt1_o;
  logic        flag_o, flag1_o, hi_ovf_o, hi_ovf1_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic seen_hi = 1'b0;
  logic seen_hi1 = 1'b0;

  always #2 clk_i = ~clk_i;

  tmr_chan dut_i (
    .clk_i, .rst_ni, .mc_en_i, .ext_cnt_i, .ext_gate_i, .run_i, .ctrl_i,
    .other_run_i, .wr_lo_i, .wr_hi_i, .wr_data_i, .flag_clr_i,
    .cnt_o(cnt_o), .flag_o(flag_o), .hi_ovf_o(hi_ovf_o)
  );

  tmr_chan #(.SPLIT_EN(1'b0)) dut1_i (
    .clk_i, .rst_ni, .mc_en_i, .ext_cnt_i, .ext_gate_i, .run_i, .ctrl_i,
    .other_run_i, .wr_lo_i, .wr_hi_i, .wr_data_i, .flag_clr_i,
    .cnt_o(cnt1_o), .flag_o(flag1_o), .hi_ovf_o(hi_ovf1_o)
  );

  always @(posedge clk_i) begin
    if (hi_ovf_o)  seen_hi  <= 1'b1;
    if (hi_ovf1_o) seen_hi1 <= 1'b1;
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0001, 8'h00, 8'h00, 8'd5,  16'h0005, 1'b0}, // R7
    '{4'b0001, 8'hFF, 8'hFE, 8'd3,  16'h0001, 1'b1}, // R7 wrap
    '{4'b0000, 8'h00, 8'h1E, 8'd3,  16'h0101, 1'b0}, // R6 carry
    '{4'b0000, 8'hFF, 8'hFF, 8'd1,  16'h00E0, 1'b1}, // R6 wrap, upper bits kept
    '{4'b0010, 8'hF0, 8'hFE, 8'd3,  16'hF0F1, 1'b1}, // R8 reload
    '{4'b0010, 8'h10, 8'h00, 8'd4,  16'h1004, 1'b0}, // R8
    '{4'b0000, 8'h12, 8'hA0, 8'd40, 16'h13A8, 1'b0}, // R6 long run
    '{4'b0001, 8'h00, 8'hFF, 8'd1,  16'h0100, 1'b0}, // R7 byte carry
    '{4'b0011, 8'h55, 8'hFE, 8'd2,  16'h5500, 1'b1}  // R9 low half only
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mc(input int n);
    for (int k = 0; k < n; k++) begin
      mc_en_i = 1'b1;
      @(negedge clk_i);
      mc_en_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic wr(input logic hi_sel, input logic [7:0] val);
    wr_hi_i = hi_sel;
    wr_lo_i = ~hi_sel;
    wr_data_i = val;
    @(negedge clk_i);
    wr_hi_i = 1'b0;
    wr_lo_i = 1'b0;
  endtask

  task automatic clr();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cnt", cnt_o, 16'h0000);
    chk("R1 flag", {15'd0, flag_o}, 16'd0);
    chk("R1 hi_ovf", {15'd0, hi_ovf_o}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R4 R6 R7 R8 vector table, timer source
    for (int i = 0; i < NVEC; i++) begin
      run_i = 1'b0;
      ctrl_i = VECS[i].ctrl;
      wr(1'b1, VECS[i].hi);
      wr(1'b0, VECS[i].lo);
      clr();
      run_i = 1'b1;
      mc(int'(VECS[i].n));
      run_i = 1'b0;
      chk($sformatf("R2 vec%0d cnt", i), cnt_o, VECS[i].exp_cnt);
      chk($sformatf("R10 vec%0d flag", i), {15'd0, flag_o}, {15'd0, VECS[i].exp_flag});
    end

    // R4 no enable, no change
    ctrl_i = 4'b0001; run_i = 1'b1;
    wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    repeat (5) @(negedge clk_i);
    chk("R4 idle clocks", cnt_o, 16'h0000);

    // R3 gating
    ctrl_i = 4'b1001; ext_gate_i = 1'b0;
    mc(3);
    chk("R3 gate low", cnt_o, 16'h0000);
    ext_gate_i = 1'b1;
    mc(3);
    chk("R3 gate high", cnt_o, 16'h0003);
    run_i = 1'b0;
    mc(2);
    chk("R3 run off", cnt_o, 16'h0003);

    // R5 external edges
    ctrl_i = 4'b0101; ext_gate_i = 1'b0;
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    run_i = 1'b1;
    ext_cnt_i = 1'b1; mc(1);
    ext_cnt_i = 1'b0; mc(1);
    chk("R5 detect no count yet", cnt_o, 16'h0000);
    mc(1);
    chk("R5 count after detect", cnt_o, 16'h0001);
    mc(3);
    chk("R5 low level no count", cnt_o, 16'h0001);
    ext_cnt_i = 1'b1; mc(2);
    chk("R5 rising no count", cnt_o, 16'h0001);
    ext_cnt_i = 1'b0; mc(2);
    chk("R5 second edge", cnt_o, 16'h0002);
    run_i = 1'b0;

    // R10 set beats clear
    ctrl_i = 4'b0001;
    wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    clr();
    run_i = 1'b1;
    mc_en_i = 1'b1; flag_clr_i = 1'b1;
    @(negedge clk_i);
    mc_en_i = 1'b0; flag_clr_i = 1'b0;
    run_i = 1'b0;
    @(negedge clk_i);
    chk("R10 set wins", {15'd0, flag_o}, 16'd1);
    chk("R7 wrap to zero", cnt_o, 16'h0000);
    repeat (3) @(negedge clk_i);
    chk("R10 sticky", {15'd0, flag_o}, 16'd1);
    clr();
    chk("R10 cleared", {15'd0, flag_o}, 16'd0);

    // R11 write beats count
    ctrl_i = 4'b0001;
    wr(1'b1, 8'h07); wr(1'b0, 8'h10);
    run_i = 1'b1;
    mc_en_i = 1'b1; wr_lo_i = 1'b1; wr_data_i = 8'h80;
    @(negedge clk_i);
    mc_en_i = 1'b0; wr_lo_i = 1'b0;
    run_i = 1'b0;
    @(negedge clk_i);
    chk("R11 write priority", cnt_o, 16'h0780);

    // R9 split mode, both channel variants
    ctrl_i = 4'b0011;
    wr(1'b1, 8'hFE); wr(1'b0, 8'h00);
    clr();
    seen_hi = 1'b0; seen_hi1 = 1'b0;
    other_run_i = 1'b1; run_i = 1'b1;
    mc(2);
    other_run_i = 1'b0; run_i = 1'b0;
    @(negedge clk_i);
    chk("R9 split cnt", cnt_o, 16'h0002);
    chk("R9 hi pulse", {15'd0, seen_hi}, 16'd1);
    chk("R9 own flag untouched", {15'd0, flag_o}, 16'd0);
    chk("R9 non-split holds", cnt1_o, 16'hFE00);
    chk("R9 non-split no pulse", {15'd0, seen_hi1}, 16'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule